// File: doc/BRIEF.md
# Segment Protection and Fault Encoder

This block follows address translation in a 32-bit load/store pipeline. For each accepted check it takes the effective address, the access kind (load, store or instruction fetch) and the privilege state. It then picks one of sixteen segment registers using the top four address bits and works out the protection key from that register's two key bits. The key and the page-protection field returned by the table walker give the read, write and execute rights, and these are compared against what the access needs. A hit in the block-translation array skips the segment stage. A direct-store segment is only flagged. When translation is disabled for the access kind, the effective address passes through unchanged.

Every check gives a registered result one cycle after acceptance: a grant carrying the real address and rights, a direct-store flag, or a fault. A fault keeps a fixed status code. For data faults it also keeps the faulting address. It is held until it is acknowledged, and no new check is accepted while a fault is pending.

Top module: `seg_prot_checker`

## Requirements
- R1: The protection key is segment bit 29 when `req_user` is 1 and segment bit 30 when `req_user` is 0. The segment is chosen by `req_ea[31:28]`.
- R2: With key 0, protection values 0, 1 and 2 grant read and write, and value 3 grants read only. Rights are encoded as bit 0 read, bit 1 write and bit 2 execute.
- R3: With key 1, value 0 grants no read or write, values 1 and 3 grant read only, and value 2 grants read and write.
- R4: Execute is granted only when segment bit 28 (no-execute) is clear. A fetch from a no-execute segment faults with instruction code 0x10000000, even when the walker hits.
- R5: A walker miss faults with instruction code 0x40000000 for fetches, data status 0x40000000 for loads and 0x42000000 for stores.
- R6: A rights violation faults with instruction code 0x08000000, data status 0x08000000 for loads and 0x0A000000 for stores. A data fault latches the effective address in `fault_addr`. An instruction fault leaves `fault_addr` at 0.
- R7: When translation is off for the access kind (`inst_xlat_on` for fetches, `data_xlat_on` otherwise), the check grants with `res_addr` equal to the effective address and rights 3'b111, whatever the segment holds.
- R8: A block-translation hit bypasses the segment (direct-store and no-execute bits included). Its rights come from `blk_rights`, it grants `xlat_addr`, and it faults with the R6 codes on violation.
- R9: A segment with bit 31 set and no block hit gives `res_dstore` = 1 and `res_grant` = 0, and raises no fault.
- R10: A fault holds `fault_pending`, `fault_inst`, `fault_code` and `fault_addr` stable until `fault_ack`. Meanwhile `req_ready` is 0, requests give no result and do not change the held fault.
- R11: Results appear in the cycle after acceptance as a one-cycle `res_valid` pulse. A translated grant returns `xlat_addr` and the decoded rights. Access kind encoding is 0 load, 1 store, 2 fetch, and 3 behaves as load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Check request |
| req_ready | output | 1 | Check can be accepted (no fault pending) |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_ea | input | 32 | Effective address |
| req_user | input | 1 | 1 = user state, 0 = supervisor |
| inst_xlat_on | input | 1 | Fetch translation enabled |
| data_xlat_on | input | 1 | Data translation enabled |
| seg_regs | input | 512 | Sixteen 32-bit segment registers, register n at bits n*32 upward |
| blk_hit | input | 1 | Block-translation hit |
| blk_rights | input | 3 | Rights of the block hit |
| walk_hit | input | 1 | Table walker found an entry |
| walk_pp | input | 2 | Page-protection value of the entry |
| xlat_addr | input | 32 | Real address from walker or block array |
| res_valid | output | 1 | Result pulse |
| res_grant | output | 1 | Access granted |
| res_dstore | output | 1 | Direct-store segment flagged |
| res_addr | output | 32 | Real address of a grant |
| res_rights | output | 3 | Rights of a grant |
| fault_pending | output | 1 | Fault held |
| fault_inst | output | 1 | Held fault is an instruction fault |
| fault_code | output | 32 | Instruction code or data status word |
| fault_addr | output | 32 | Faulting address (data faults) |
| fault_ack | input | 1 | Clears a held fault |

## Verification
The hardest case to reach is a page-rights instruction fault. The no-execute check comes before the walk, and key 1 with value 0 still leaves execute. So a fetch that reaches the page check is always allowed to execute. The bench therefore produces the 0x08000000 instruction code through a block-translation hit whose rights lack execute. It also holds a fault while it keeps offering new requests, to show that they are refused.

// File: rtl/seg_prot_pkg.sv
package seg_prot_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    CZ_NONE = 2'd0,
    CZ_NOEX = 2'd1,
    CZ_MISS = 2'd2,
    CZ_VIOL = 2'd3
  } cause_e;

  localparam int SEG_W     = 32;
  localparam int SB_DSTORE = 31;
  localparam int SB_KSUP   = 30;
  localparam int SB_KUSR   = 29;
  localparam int SB_NOEX   = 28;

  localparam int RT_RD = 0;
  localparam int RT_WR = 1;
  localparam int RT_EX = 2;

  localparam logic [31:0] FC_NOEX       = 32'h1000_0000;
  localparam logic [31:0] FC_MISS       = 32'h4000_0000;
  localparam logic [31:0] FC_MISS_STORE = 32'h4200_0000;
  localparam logic [31:0] FC_VIOL       = 32'h0800_0000;
  localparam logic [31:0] FC_VIOL_STORE = 32'h0A00_0000;
endpackage

// File: rtl/seg_key_sel.sv
module seg_key_sel
  import seg_prot_pkg::*;
#(
  parameter int SEG_N = 16,
  localparam int SELW = $clog2(SEG_N)
) (
  input  logic [SEG_N*SEG_W-1:0] seg_regs,
  input  logic [SELW-1:0]        sel,
  input  logic                   user,
  output logic                   dstore,
  output logic                   noex,
  output logic                   key
);
  logic [SEG_W-1:0] seg_arr [SEG_N];
  logic [SEG_W-1:0] cur;
  logic             unused_seg_bits;

  for (genvar g = 0; g < SEG_N; g++) begin : g_unpack
    assign seg_arr[g] = seg_regs[g*SEG_W +: SEG_W];
  end

  assign cur    = seg_arr[sel];
  assign dstore = cur[SB_DSTORE];
  assign noex   = cur[SB_NOEX];
  assign key    = user ? cur[SB_KUSR] : cur[SB_KSUP];
  assign unused_seg_bits = ^cur[SB_NOEX-1:0];
endmodule

// File: rtl/prot_rights_dec.sv
module prot_rights_dec
  import seg_prot_pkg::*;
(
  input  logic       key,
  input  logic [1:0] pp,
  input  logic       noex,
  output logic [2:0] rights
);
  logic rd, wr;

  always_comb begin
    if (!key) begin
      rd = 1'b1;
      wr = (pp != 2'd3);
    end else begin
      rd = (pp != 2'd0);
      wr = (pp == 2'd2);
    end
    rights        = '0;
    rights[RT_RD] = rd;
    rights[RT_WR] = wr;
    rights[RT_EX] = !noex;
  end

  // R2: key 0 always leaves read access
  always_comb begin
    p_key0_read_r2: assert (key || rights[RT_RD])
      else $error("key 0 without read");
  end
endmodule

// File: rtl/fault_code_gen.sv
module fault_code_gen
  import seg_prot_pkg::*;
(
  input  cause_e      cause,
  input  acc_e        kind,
  output logic        is_inst,
  output logic [31:0] code
);
  logic is_store;

  assign is_inst  = (kind == ACC_FETCH);
  assign is_store = (kind == ACC_STORE);

  always_comb begin
    unique case (cause)
      CZ_NOEX: code = FC_NOEX;
      CZ_MISS: code = is_store ? FC_MISS_STORE : FC_MISS;
      CZ_VIOL: code = is_store ? FC_VIOL_STORE : FC_VIOL;
      default: code = '0;
    endcase
  end
endmodule

// File: rtl/seg_prot_checker.sv
module seg_prot_checker
  import seg_prot_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SEG_N = 16,
  localparam int SELW = $clog2(SEG_N)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [1:0]             req_kind,
  input  logic [AW-1:0]          req_ea,
  input  logic                   req_user,
  input  logic                   inst_xlat_on,
  input  logic                   data_xlat_on,
  input  logic [SEG_N*SEG_W-1:0] seg_regs,
  input  logic                   blk_hit,
  input  logic [2:0]             blk_rights,
  input  logic                   walk_hit,
  input  logic [1:0]             walk_pp,
  input  logic [AW-1:0]          xlat_addr,
  output logic                   res_valid,
  output logic                   res_grant,
  output logic                   res_dstore,
  output logic [AW-1:0]          res_addr,
  output logic [2:0]             res_rights,
  output logic                   fault_pending,
  output logic                   fault_inst,
  output logic [31:0]            fault_code,
  output logic [AW-1:0]          fault_addr,
  input  logic                   fault_ack
);
  acc_e        kind;
  logic        accept, xlat_on;
  logic        seg_ds, seg_nx, seg_key;
  logic [2:0]  page_rights, need;
  cause_e      cause;
  logic        grant_n, dstore_n;
  logic [AW-1:0] addr_n;
  logic [2:0]  rights_n;
  logic        code_inst;
  logic [31:0] code_n;

  logic          rv_q, gr_q, ds_q, fp_q, fi_q;
  logic [AW-1:0] ad_q, fa_q;
  logic [2:0]    rt_q;
  logic [31:0]   fc_q;

  assign kind      = acc_e'(req_kind);
  assign req_ready = !fp_q;
  assign accept    = req_valid && req_ready;
  assign xlat_on   = (kind == ACC_FETCH) ? inst_xlat_on : data_xlat_on;

  seg_key_sel #(.SEG_N(SEG_N)) u_key (
    .seg_regs (seg_regs),
    .sel      (req_ea[AW-1 -: SELW]),
    .user     (req_user),
    .dstore   (seg_ds),
    .noex     (seg_nx),
    .key      (seg_key)
  );

  prot_rights_dec u_dec (
    .key    (seg_key),
    .pp     (walk_pp),
    .noex   (seg_nx),
    .rights (page_rights)
  );

  fault_code_gen u_code (
    .cause   (cause),
    .kind    (kind),
    .is_inst (code_inst),
    .code    (code_n)
  );

  always_comb begin
    need = '0;
    unique case (kind)
      ACC_STORE: need[RT_WR] = 1'b1;
      ACC_FETCH: need[RT_EX] = 1'b1;
      default:   need[RT_RD] = 1'b1;
    endcase
  end

  // Cause priority: real mode, block hit, direct store, no-execute, walk, rights
  always_comb begin
    cause    = CZ_NONE;
    grant_n  = 1'b0;
    dstore_n = 1'b0;
    addr_n   = '0;
    rights_n = '0;
    if (!xlat_on) begin
      grant_n  = 1'b1;
      addr_n   = req_ea;
      rights_n = 3'b111;
    end else if (blk_hit) begin
      if ((need & ~blk_rights) != 3'b000) begin
        cause = CZ_VIOL;
      end else begin
        grant_n  = 1'b1;
        addr_n   = xlat_addr;
        rights_n = blk_rights;
      end
    end else if (seg_ds) begin
      dstore_n = 1'b1;
    end else if (kind == ACC_FETCH && seg_nx) begin
      cause = CZ_NOEX;
    end else if (!walk_hit) begin
      cause = CZ_MISS;
    end else if ((need & ~page_rights) != 3'b000) begin
      cause = CZ_VIOL;
    end else begin
      grant_n  = 1'b1;
      addr_n   = xlat_addr;
      rights_n = page_rights;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      gr_q <= 1'b0;
      ds_q <= 1'b0;
      ad_q <= '0;
      rt_q <= '0;
    end else begin
      rv_q <= accept;
      if (accept) begin
        gr_q <= grant_n;
        ds_q <= dstore_n;
        ad_q <= addr_n;
        rt_q <= rights_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_q <= 1'b0;
      fi_q <= 1'b0;
      fc_q <= '0;
      fa_q <= '0;
    end else if (accept && cause != CZ_NONE) begin
      fp_q <= 1'b1;
      fi_q <= code_inst;
      fc_q <= code_n;
      fa_q <= code_inst ? '0 : req_ea;
    end else if (fp_q && fault_ack) begin
      fp_q <= 1'b0;
    end
  end

  assign res_valid     = rv_q;
  assign res_grant     = gr_q;
  assign res_dstore    = ds_q;
  assign res_addr      = ad_q;
  assign res_rights    = rt_q;
  assign fault_pending = fp_q;
  assign fault_inst    = fi_q;
  assign fault_code    = fc_q;
  assign fault_addr    = fa_q;

  p_fault_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pending && !fault_ack |=> fault_pending && $stable(fault_code) && $stable(fault_addr))
    else $error("held fault changed");

  p_no_result_while_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pending && !fault_ack |=> !res_valid)
    else $error("result while fault held");

  p_code_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pending |-> (fault_code == FC_NOEX || fault_code == FC_MISS ||
                       fault_code == FC_MISS_STORE || fault_code == FC_VIOL ||
                       fault_code == FC_VIOL_STORE))
    else $error("illegal fault code");

  p_inst_no_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pending && fault_inst |-> fault_addr == '0 && fault_code != FC_MISS_STORE &&
                                     fault_code != FC_VIOL_STORE)
    else $error("instruction fault carries data status");

  p_grant_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_grant && res_dstore))
    else $error("grant with direct store");

  p_grant_no_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) && res_grant |-> !$rose(fault_pending))
    else $error("grant and fault together");
endmodule

// File: tb/sim_seg_prot_checker.sv
module sim_seg_prot_checker;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        req_valid, req_ready;
  logic [1:0]  req_kind;
  logic [31:0] req_ea;
  logic        req_user, inst_xlat_on, data_xlat_on;
  logic [511:0] seg_regs;
  logic        blk_hit;
  logic [2:0]  blk_rights;
  logic        walk_hit;
  logic [1:0]  walk_pp;
  logic [31:0] xlat_addr;
  logic        res_valid, res_grant, res_dstore;
  logic [31:0] res_addr;
  logic [2:0]  res_rights;
  logic        fault_pending, fault_inst;
  logic [31:0] fault_code, fault_addr;
  logic        fault_ack;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  seg_prot_checker u0 (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [2:0] model(bit key, logic [1:0] pp, bit nx);
    logic [2:0] r;
    if (!key) r = (pp == 2'd3) ? 3'b001 : 3'b011;
    else if (pp == 2'd0) r = 3'b000;
    else if (pp == 2'd2) r = 3'b011;
    else r = 3'b001;
    r[2] = !nx;
    return r;
  endfunction

  task automatic issue(logic [1:0] kind, logic [31:0] ea, bit user, bit xon,
                       bit bh, logic [2:0] br, bit wh, logic [1:0] pp, logic [31:0] xa);
    @(negedge clk);
    req_kind = kind; req_ea = ea; req_user = user;
    inst_xlat_on = xon; data_xlat_on = xon;
    blk_hit = bh; blk_rights = br; walk_hit = wh; walk_pp = pp; xlat_addr = xa;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ack();
    fault_ack = 1'b1;
    @(negedge clk);
    fault_ack = 1'b0;
  endtask

  task automatic expect_grant(string req, logic [31:0] a, logic [2:0] r);
    chk(req, {res_valid, res_grant, res_dstore, fault_pending}, 32'b1100);
    chk(req, res_addr, a);
    chk(req, res_rights, r);
  endtask

  task automatic expect_fault(string req, bit inst, logic [31:0] code, logic [31:0] fa);
    chk(req, {res_valid, res_grant, fault_pending, fault_inst}, {3'b101, inst});
    chk(req, fault_code, code);
    chk(req, fault_addr, fa);
    ack();
    chk(req, fault_pending, 0);
  endtask

  task automatic t_reset();
    chk("R10 reset", {res_valid, fault_pending, req_ready}, 32'b001);
  endtask

  task automatic t_real_mode();
    issue(2, 32'h3123_4567, 0, 0, 0, 0, 0, 0, 32'hDEAD_0000);
    expect_grant("R7 fetch off", 32'h3123_4567, 3'b111);
    issue(1, 32'h4000_0010, 1, 0, 0, 0, 0, 0, 32'h0);
    expect_grant("R7 store off", 32'h4000_0010, 3'b111);
  endtask

  task automatic t_sweep(string req, logic [3:0] seg, bit key);
    for (int pp = 0; pp < 4; pp++) begin
      for (int k = 0; k < 2; k++) begin
        logic [2:0] r;
        logic [31:0] ea;
        r  = model(key, pp[1:0], 0);
        ea = {seg, 8'h00, pp[1:0], k[1:0], 16'h1234};
        issue(k[1:0], ea, 0, 1, 0, 0, 1, pp[1:0], 32'h8000_0000 + pp);
        if ((k == 0 && r[0]) || (k == 1 && r[1]))
          expect_grant({req, " R11 grant"}, 32'h8000_0000 + pp, r);
        else
          expect_fault({req, " R6 viol"}, 0, k == 1 ? 32'h0A00_0000 : 32'h0800_0000, ea);
      end
    end
  endtask

  task automatic t_key_select();
    issue(0, 32'h1000_0000, 0, 1, 0, 0, 1, 0, 32'h100);
    expect_fault("R1 sup key set", 0, 32'h0800_0000, 32'h1000_0000);
    issue(0, 32'h1000_0000, 1, 1, 0, 0, 1, 0, 32'h100);
    expect_grant("R1 user key clear", 32'h100, 3'b111);
    issue(0, 32'h2000_0004, 1, 1, 0, 0, 1, 0, 32'h200);
    expect_fault("R1 user key set", 0, 32'h0800_0000, 32'h2000_0004);
    issue(0, 32'h2000_0004, 0, 1, 0, 0, 1, 0, 32'h200);
    expect_grant("R1 sup key clear", 32'h200, 3'b111);
  endtask

  task automatic t_noexec();
    issue(2, 32'h3000_0040, 0, 1, 0, 0, 1, 2, 32'h300);
    expect_fault("R4 nx fetch", 1, 32'h1000_0000, 0);
    issue(2, 32'h0000_0040, 0, 1, 0, 0, 1, 2, 32'h340);
    expect_grant("R4 exec allowed", 32'h340, 3'b111);
    issue(0, 32'h3000_0080, 0, 1, 0, 0, 1, 2, 32'h380);
    expect_grant("R4 nx load", 32'h380, 3'b011);
  endtask

  task automatic t_miss();
    issue(0, 32'h0ABC_0000, 0, 1, 0, 0, 0, 0, 0);
    expect_fault("R5 load miss", 0, 32'h4000_0000, 32'h0ABC_0000);
    issue(1, 32'h0ABC_0008, 0, 1, 0, 0, 0, 0, 0);
    expect_fault("R5 store miss", 0, 32'h4200_0000, 32'h0ABC_0008);
    issue(2, 32'h0ABC_0010, 0, 1, 0, 0, 0, 0, 0);
    expect_fault("R5 fetch miss", 1, 32'h4000_0000, 0);
    issue(3, 32'h0ABC_0018, 0, 1, 0, 0, 0, 0, 0);
    expect_fault("R11 kind 3 as load", 0, 32'h4000_0000, 32'h0ABC_0018);
  endtask

  task automatic t_block();
    issue(1, 32'h4000_1000, 0, 1, 1, 3'b011, 0, 0, 32'h7700_1000);
    expect_grant("R8 block over dstore", 32'h7700_1000, 3'b011);
    issue(2, 32'h3000_2000, 0, 1, 1, 3'b101, 0, 0, 32'h7700_2000);
    expect_grant("R8 block over nx", 32'h7700_2000, 3'b101);
    issue(1, 32'h0000_3000, 0, 1, 1, 3'b101, 1, 0, 32'h7700_3000);
    expect_fault("R8 block store viol", 0, 32'h0A00_0000, 32'h0000_3000);
    issue(2, 32'h0000_4000, 0, 1, 1, 3'b011, 1, 0, 32'h7700_4000);
    expect_fault("R6 inst viol", 1, 32'h0800_0000, 0);
  endtask

  task automatic t_dstore();
    issue(0, 32'h4000_5000, 0, 1, 0, 0, 1, 0, 32'h500);
    chk("R9 dstore", {res_valid, res_grant, res_dstore, fault_pending}, 32'b1010);
    issue(2, 32'h4000_5000, 0, 1, 0, 0, 0, 0, 32'h500);
    chk("R9 dstore fetch", {res_valid, res_grant, res_dstore, fault_pending}, 32'b1010);
  endtask

  task automatic t_hold();
    issue(1, 32'h0DDD_0000, 0, 1, 0, 0, 0, 0, 0);
    chk("R10 raised", fault_code, 32'h4200_0000);
    issue(0, 32'h0000_0000, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 blocked", {res_valid, req_ready, fault_pending}, 32'b001);
    chk("R10 code held", fault_code, 32'h4200_0000);
    chk("R10 addr held", fault_addr, 32'h0DDD_0000);
    repeat (3) @(negedge clk);
    chk("R10 still held", fault_pending, 1);
    ack();
    chk("R10 released", {fault_pending, req_ready}, 32'b01);
    issue(0, 32'h0000_0600, 0, 0, 0, 0, 0, 0, 0);
    expect_grant("R10 accepted after ack", 32'h0000_0600, 3'b111);
  endtask

  initial begin
    #(CLK_PERIOD*50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; fault_ack = 0;
    req_kind = 0; req_ea = 0; req_user = 0;
    inst_xlat_on = 0; data_xlat_on = 0;
    blk_hit = 0; blk_rights = 0; walk_hit = 0; walk_pp = 0; xlat_addr = 0;
    seg_regs = '0;
    seg_regs[1*32 +: 32] = 32'h4000_0000;
    seg_regs[2*32 +: 32] = 32'h2000_0000;
    seg_regs[3*32 +: 32] = 32'h1000_0000;
    seg_regs[4*32 +: 32] = 32'h8000_0000;
    seg_regs[5*32 +: 32] = 32'h6000_0000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_real_mode();
    t_sweep("R2", 4'd0, 0);
    t_sweep("R3", 4'd5, 1);
    t_key_select();
    t_noexec();
    t_miss();
    t_block();
    t_dstore();
    t_hold();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule